// File: doc/BRIEF.md
# Power Button Event Controller

This block turns an active-low power button into power-management events. The raw pin first passes through a short synchronizer and a counter-based debouncer. A falling edge of the filtered level counts as a press. The block keeps its own copy of the system state. That copy changes only when the platform reports that a sleep transition has finished, or when the block itself forces soft-off.

A press while the confirmed state is working (0) sets the press status bit. If the press enable bit is also set, the block raises the system control interrupt. If the interrupt-routing control bit is clear, the same press cuts the power outputs at once. A press while the confirmed state is any sleep state (1 to 5) sets the press status bit, sends a one-cycle wake pulse whatever the enable bit holds, and restores the power outputs. If the button is held for a long time, the press status is dropped, a separate override status bit is set, the outputs are cut and the confirmed state becomes soft-off (5).

Software reaches the status, enable and control registers through a small word interface. The status bits are write-one-to-clear.

Top module: `pwrbtn_evt_ctrl`

## Requirements
- R1: The filtered button level follows the raw pin only after the 2-stage-synchronized value has differed from it for DEB_CYCLES consecutive clocks. A low glitch shorter than that sets no status bit.
- R2: A press is a high-to-low change of the filtered level. In the working state a press sets status bit 8 (address 0). The raw pin never does this directly.
- R3: The confirmed state (address 2, bits 10:8, reads 0 for working and 1 to 5 for the sleep states) loads sleep_req_i only in a cycle where trans_done_i is 1. Requesting a sleep state without the done strobe leaves presses on the working-state path.
- R4: A press while the confirmed state is nonzero sets status bit 8 and pulses wake_o high for exactly one cycle, whatever enable bit 8 holds.
- R5: sci_o is 1 exactly when the confirmed state is 0 and both status bit 8 and enable bit 8 (address 1) are 1.
- R6: A press in the working state while control bit 0 (address 2, interrupt routing enable) is 0 drives onctl_no to 1 and pwrcnt_no to 2'b11 and sets the confirmed state to 5, whatever enable bit 8 holds.
- R7: If the filtered level stays low for HOLD_CYCLES clocks, the override fires once. It clears status bit 8, sets status bit 11, cuts the outputs as in R6 and sets the confirmed state to 5. It does not fire again until the button has been released.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a hardware set and a software clear meet in the same cycle, the bit ends up set.
- R9: After reset all registers read 0, sci_o and wake_o are 0, and onctl_no and pwrcnt_no are 0 (power on). Address 1 keeps only bit 8, address 2 keeps only bit 0, and address 3 reads 0.
- R10: A wake press (R4) drives onctl_no and pwrcnt_no back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 1 | Raw active-low power button |
| sleep_req_i | input | 3 | Requested system state, 0 working, 1..5 sleep |
| trans_done_i | input | 1 | Strobe: the requested state has been reached |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on address) |
| sci_o | output | 1 | System control interrupt request, level |
| wake_o | output | 1 | One-cycle wake request |
| onctl_no | output | 1 | Active-low power-on control |
| pwrcnt_no | output | 2 | Active-low power control pair |

## Verification
A corrupted debounce count or synchronizer shows up as a status bit or a wake pulse that comes one or more clocks early or late against the reference model. A glitch that leaks through shows up as a status bit that should never appear. A wrong confirmed state is visible on the control register readback in the very next cycle. It also sends the next press down the wrong path, which changes wake_o, sci_o or the power outputs within the cycle after the press edge. A hold counter that is off by one moves the override by one clock, and a missing re-arm guard sets the override status bit again after software has cleared it during one continuous hold.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned STATE_W   = 3;
  localparam int unsigned ADDR_W    = 2;

  localparam int unsigned STS_PRESS_BIT = 8;
  localparam int unsigned STS_OVR_BIT   = 11;
  localparam int unsigned EN_PRESS_BIT  = 8;
  localparam int unsigned CTL_SCI_BIT   = 0;
  localparam int unsigned CTL_STATE_LSB = 8;

  localparam logic [STATE_W-1:0] ST_WORKING = 3'd0;
  localparam logic [STATE_W-1:0] ST_SOFTOFF = 3'd5;

  typedef enum logic [ADDR_W-1:0] {
    A_STS = 2'd0,
    A_EN  = 2'd1,
    A_CTL = 2'd2,
    A_RSV = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pbe_debounce.sv
module pbe_debounce #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o,
  output logic fell_o
);
  localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q, prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= raw_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end
  endgenerate

  assign sync_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      prev_q <= filt_q;
      if (sync_o == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        filt_q <= sync_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
  assign fell_o = prev_q & ~filt_q;
endmodule

// File: rtl/pbe_hold_timer.sv
module pbe_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  output logic ovr_o
);
  localparam int unsigned HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] cnt_q;
  logic          fired_q;

  assign ovr_o = ~filt_i & ~fired_q & (cnt_q == HOLD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (filt_i) begin
      cnt_q   <= '0;       // release re-arms
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      if (cnt_q == HOLD_LAST) fired_q <= 1'b1;
      else                    cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pbe_regs.sv
module pbe_regs
  import pwrbtn_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fell_i,
  input  logic               ovr_i,
  input  logic [STATE_W-1:0] sleep_req_i,
  input  logic               trans_done_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               sci_o,
  output logic               wake_o,
  output logic               cut_o,
  output logic [REG_W-1:0]   sts_o,
  output logic [REG_W-1:0]   en_o,
  output logic [STATE_W-1:0] conf_o,
  output logic               force_off_o
);
  localparam logic [REG_W-1:0] STS_MASK = (REG_W'(1) << STS_PRESS_BIT) |
                                          (REG_W'(1) << STS_OVR_BIT);
  localparam logic [REG_W-1:0] EN_MASK  = REG_W'(1) << EN_PRESS_BIT;
  localparam logic [REG_W-1:0] CTL_MASK = REG_W'(1) << CTL_SCI_BIT;

  logic [REG_W-1:0]   sts_q, en_q, ctl_q, sts_clr, sts_set, sts_d;
  logic [STATE_W-1:0] conf_q;
  logic               cut_q, wake_q;
  logic               awake, press_awake, press_sleep, force_off;
  reg_addr_e          addr;

  assign addr        = reg_addr_e'(reg_addr_i);
  assign awake       = (conf_q == ST_WORKING);
  assign press_awake = fell_i & awake;
  assign press_sleep = fell_i & ~awake;
  assign force_off   = ovr_i | (press_awake & ~ctl_q[CTL_SCI_BIT]);

  always_comb begin
    sts_clr = (reg_wr_i && addr == A_STS) ? (reg_wdata_i & STS_MASK) : '0;
    sts_set = '0;
    sts_set[STS_PRESS_BIT] = fell_i;
    sts_set[STS_OVR_BIT]   = ovr_i;
    sts_d = (sts_q & ~sts_clr) | sts_set;   // set beats clear
    if (ovr_i) sts_d[STS_PRESS_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      conf_q <= ST_WORKING;
      cut_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      wake_q <= press_sleep;
      if (reg_wr_i && addr == A_EN)  en_q  <= reg_wdata_i & EN_MASK;
      if (reg_wr_i && addr == A_CTL) ctl_q <= reg_wdata_i & CTL_MASK;
      if (force_off)         conf_q <= ST_SOFTOFF;
      else if (trans_done_i) conf_q <= sleep_req_i;
      if (force_off)        cut_q <= 1'b1;
      else if (press_sleep) cut_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_STS: reg_rdata_o = sts_q;
      A_EN:  reg_rdata_o = en_q;
      A_CTL: begin
        reg_rdata_o = ctl_q;
        reg_rdata_o[CTL_STATE_LSB +: STATE_W] = conf_q;
      end
      A_RSV: reg_rdata_o = '0;
    endcase
  end

  assign sci_o       = awake & sts_q[STS_PRESS_BIT] & en_q[EN_PRESS_BIT];
  assign wake_o      = wake_q;
  assign cut_o       = cut_q;
  assign sts_o       = sts_q;
  assign en_o        = en_q;
  assign conf_o      = conf_q;
  assign force_off_o = force_off;
endmodule

// File: rtl/pwrbtn_evt_ctrl.sv
module pwrbtn_evt_ctrl
  import pwrbtn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 50000,
  parameter int unsigned HOLD_CYCLES = 200_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        btn_ni,
  input  logic [2:0]  sleep_req_i,
  input  logic        trans_done_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        sci_o,
  output logic        wake_o,
  output logic        onctl_no,
  output logic [1:0]  pwrcnt_no
);
  logic               btn_sync, btn_filt, btn_fell, ovr_evt, cut;
  logic               force_off;
  logic [REG_W-1:0]   sts_q, en_q;
  logic [STATE_W-1:0] conf_q;

  pbe_debounce #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYCLES (DEB_CYCLES)
  ) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (btn_ni),
    .sync_o(btn_sync),
    .filt_o(btn_filt),
    .fell_o(btn_fell)
  );

  pbe_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .filt_i(btn_filt),
    .ovr_o (ovr_evt)
  );

  pbe_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fell_i      (btn_fell),
    .ovr_i       (ovr_evt),
    .sleep_req_i (sleep_req_i),
    .trans_done_i(trans_done_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .sci_o       (sci_o),
    .wake_o      (wake_o),
    .cut_o       (cut),
    .sts_o       (sts_q),
    .en_o        (en_q),
    .conf_o      (conf_q),
    .force_off_o (force_off)
  );

  assign onctl_no  = cut;
  assign pwrcnt_no = {2{cut}};
endmodule

// File: rtl/pwrbtn_evt_ctrl_chk.sv
module pwrbtn_evt_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trans_done_i,
  input logic        btn_sync,
  input logic        btn_filt,
  input logic        btn_fell,
  input logic        ovr_evt,
  input logic        force_off,
  input logic [15:0] sts_q,
  input logic [2:0]  conf_q,
  input logic        sci_o,
  input logic        wake_o,
  input logic        onctl_no,
  input logic [1:0]  pwrcnt_no
);
  assert_filt_follows_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_filt != $past(btn_filt)) |-> (btn_filt == $past(btn_sync)));

  assert_press_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_fell |=> sts_q[8]);

  assert_state_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trans_done_i && !force_off) |=> $stable(conf_q));

  assert_wake_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_sci_awake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> (conf_q == 3'd0));

  assert_outputs_agree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrcnt_no == {2{onctl_no}}));

  assert_override_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> (sts_q[11] && !sts_q[8] && onctl_no && conf_q == 3'd5));
endmodule

bind pwrbtn_evt_ctrl pwrbtn_evt_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trans_done_i(trans_done_i),
  .btn_sync    (btn_sync),
  .btn_filt    (btn_filt),
  .btn_fell    (btn_fell),
  .ovr_evt     (ovr_evt),
  .force_off   (force_off),
  .sts_q       (sts_q),
  .conf_q      (conf_q),
  .sci_o       (sci_o),
  .wake_o      (wake_o),
  .onctl_no    (onctl_no),
  .pwrcnt_no   (pwrcnt_no)
);

// File: tb/pwrbtn_evt_ctrl_tb.sv
module pwrbtn_evt_ctrl_tb;
  localparam int DEB  = 4;
  localparam int HOLD = 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        btn_ni = 1'b1;
  logic [2:0]  sleep_req = 3'd0;
  logic        trans_done = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        sci, wake, onctl_n;
  logic [1:0]  pwrcnt_n;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  pwrbtn_evt_ctrl #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_ni(btn_ni), .sleep_req_i(sleep_req),
    .trans_done_i(trans_done), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sci_o(sci),
    .wake_o(wake), .onctl_no(onctl_n), .pwrcnt_no(pwrcnt_n));

  // behavioural reference
  int  q_sync[$];
  bit  m_filt = 1, m_prev = 1, m_fired = 0, m_sts8 = 0, m_sts11 = 0;
  bit  m_en8 = 0, m_sci_en = 0, m_off = 0, m_wake = 0;
  int  m_run = 0, m_low = 0, m_state = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic int m_rdata(int a);
    case (a)
      0: return (int'(m_sts11) << 11) | (int'(m_sts8) << 8);
      1: return int'(m_en8) << 8;
      2: return (m_state << 8) | int'(m_sci_en);
      default: return 0;
    endcase
  endfunction

  initial begin q_sync.push_back(1); q_sync.push_back(1); end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_sync = {1, 1};
      m_filt = 1; m_prev = 1; m_fired = 0; m_sts8 = 0; m_sts11 = 0;
      m_en8 = 0; m_sci_en = 0; m_off = 0; m_wake = 0; m_run = 0; m_low = 0; m_state = 0;
    end else begin
      int s; bit press, ovr, sleeping, cut_now;
      cyc++;
      s = q_sync[1];
      press = m_prev && !m_filt;
      ovr = !m_filt && !m_fired && (m_low == HOLD - 1);
      sleeping = (m_state != 0);
      cut_now = ovr || (press && !sleeping && !m_sci_en);
      // status: clear by write, then set events
      if (reg_wr && reg_addr == 0) begin
        if (reg_wdata[8])  m_sts8 = 0;
        if (reg_wdata[11]) m_sts11 = 0;
      end
      if (press) m_sts8 = 1;
      if (ovr) begin m_sts11 = 1; m_sts8 = 0; end
      if (reg_wr && reg_addr == 1) m_en8 = reg_wdata[8];
      if (reg_wr && reg_addr == 2) m_sci_en = reg_wdata[0];
      m_wake = press && sleeping;
      if (cut_now) m_off = 1; else if (press && sleeping) m_off = 0;
      if (cut_now) m_state = 5; else if (trans_done) m_state = int'(sleep_req);
      // hold timer
      if (m_filt) begin m_low = 0; m_fired = 0; end
      else if (!m_fired) begin
        if (m_low == HOLD - 1) m_fired = 1; else m_low++;
      end
      // debounce
      m_prev = m_filt;
      if (s == int'(m_filt)) m_run = 0;
      else if (m_run == DEB - 1) begin m_run = 0; m_filt = (s != 0); end
      else m_run++;
      q_sync.push_front(int'(btn_ni));
      void'(q_sync.pop_back());
    end
  end

  always @(posedge clk) begin
    #5;
    chk("R9 rdata", int'(reg_rdata), m_rdata(int'(reg_addr)));
    chk("R4 wake_o", int'(wake), int'(m_wake));
    chk("R5 sci_o", int'(sci), int'(!m_state && m_sts8 && m_en8));
    chk("R6 onctl_no", int'(onctl_n), int'(m_off));
    chk("R10 pwrcnt_no", int'(pwrcnt_n), m_off ? 3 : 0);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic press(int low_cycles);
    @(negedge clk); btn_ni = 0;
    tick(low_cycles);
    btn_ni = 1;
    tick(12);
  endtask

  task automatic settle(int st);
    @(negedge clk); sleep_req = 3'(st); trans_done = 1;
    @(negedge clk); trans_done = 0;
  endtask

  initial begin
    int d, seen;
    tick(3);
    rst_ni = 1;
    tick(1);
    // reset state
    rd(0, d); chk("R9 reset status", d, 0);
    rd(2, d); chk("R9 reset control", d, 0);
    chk("R9 reset onctl_no", int'(onctl_n), 0);
    chk("R9 reset pwrcnt_no", int'(pwrcnt_n), 0);
    // register map
    wr(1, 16'hFFFF); rd(1, d); chk("R9 enable mask", d, 16'h0100);
    wr(2, 16'hFFFF); rd(2, d); chk("R9 control mask", d, 16'h0001);
    rd(3, d); chk("R9 reserved", d, 0);
    // glitch shorter than debounce
    @(negedge clk); btn_ni = 0; tick(2); btn_ni = 1; tick(15);
    rd(0, d); chk("R1 glitch ignored", d, 0);
    // clean press in working state
    press(12);
    rd(0, d); chk("R2 press status", d, 16'h0100);
    chk("R5 sci raised", int'(sci), 1);
    wr(0, 16'h0000); rd(0, d); chk("R8 write zero keeps", d, 16'h0100);
    wr(0, 16'h0100); rd(0, d); chk("R8 w1c clears", d, 0);
    chk("R5 sci dropped", int'(sci), 0);
    // set wins over a clear held every cycle
    @(negedge clk); reg_addr = 0; reg_wdata = 16'h0100; reg_wr = 1; btn_ni = 0;
    seen = 0;
    for (int i = 0; i < 14; i++) begin @(negedge clk); #1 if (reg_rdata[8]) seen++; end
    btn_ni = 1; tick(12); reg_wr = 0; reg_wdata = 0;
    chk("R8 set beats clear", seen, 1);
    // sleep requested but not confirmed
    @(negedge clk); sleep_req = 3'd3;
    seen = 0;
    @(negedge clk); btn_ni = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (wake) seen++; end
    btn_ni = 1; tick(12);
    chk("R3 no wake before done", seen, 0);
    rd(2, d); chk("R3 state unconfirmed", d, 16'h0001);
    wr(0, 16'h0100);
    // confirmed sleep, enable cleared
    settle(3);
    rd(2, d); chk("R3 state confirmed", d, 16'h0301);
    wr(1, 0);
    seen = 0;
    @(negedge clk); btn_ni = 0;
    for (int i = 0; i < 14; i++) begin @(negedge clk); if (wake) seen++; end
    btn_ni = 1; tick(12);
    chk("R4 one wake pulse", seen, 1);
    rd(0, d); chk("R4 status in sleep", d, 16'h0100);
    chk("R5 no sci while asleep", int'(sci), 0);
    settle(0);
    wr(0, 16'h0100);
    // routing disabled: press cuts power
    wr(2, 0);
    press(12);
    chk("R6 onctl cut", int'(onctl_n), 1);
    chk("R6 pwrcnt cut", int'(pwrcnt_n), 3);
    rd(2, d); chk("R6 soft-off state", d, 16'h0500);
    // wake from soft-off
    press(12);
    chk("R10 onctl restored", int'(onctl_n), 0);
    chk("R10 pwrcnt restored", int'(pwrcnt_n), 0);
    settle(0);
    wr(0, 16'h0900);
    // long hold override
    wr(2, 1); wr(1, 16'h0100);
    @(negedge clk); btn_ni = 0; tick(70);
    rd(0, d); chk("R7 override status", d, 16'h0800);
    chk("R7 onctl cut", int'(onctl_n), 1);
    rd(2, d); chk("R7 soft-off state", d, 16'h0501);
    wr(0, 16'h0800); tick(60);
    rd(0, d); chk("R7 fires once per hold", d, 0);
    btn_ni = 1; tick(15);
    press(12);
    chk("R10 restored after override", int'(onctl_n), 0);
    tick(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule